// File: doc/BRIEF.md
# PMBus Packet Error Code Engine

This block computes and checks the packet error code (PEC) byte for the SMBus/PMBus transactions that a slave takes part in. The byte-level side of the slave interface feeds it strobes. One marks a START, one marks each byte seen on the bus in either direction, one marks a repeated START and one marks the end of the message. The engine keeps a running CRC-8 over every byte of the message. The address and command bytes sent before a repeated START stay in that CRC, and so does the read-direction address byte sent after it.

On a read, the current CRC value is the byte the slave appends as the final byte. On a write, the command decoder supplies the message length without a PEC, counting the address byte. If the message carries exactly one more byte than that, the last byte is taken as a PEC and checked. A good check gives a one-cycle acceptance pulse. A mismatch gives a one-cycle error pulse, which feeds the alert logic. A write that ends one byte earlier has no PEC and is accepted without a check.

Top module: `smb_pec_unit`

## Requirements
- R1: After reset, `pec_o` is 0x00 and both `pec_ok_o` and `pec_err_o` are low.
- R2: A START strobe clears the CRC to 0x00, so `pec_o` reads 0x00 in the next cycle. A byte strobe in the same cycle as START is not folded in.
- R3: Each byte accepted inside a transaction updates the CRC. The CRC is CRC-8 with polynomial 0x07, processed MSB first, with no reflection and no final XOR. The new value appears on `pec_o` in the cycle after the strobe. For example, the ASCII bytes "123456789" give 0xF4.
- R4: With no START and no byte strobe, `pec_o` keeps its value.
- R5: A repeated START does not reset the CRC. Bytes after it, including the read-direction address byte, keep accumulating, so `pec_o` is the PEC covering the whole read message.
- R6: When a write message ends (end strobe with no repeated START since START) and its byte count equals `len_nopec_i`+1, a zero CRC gives a one-cycle `pec_ok_o` pulse in the cycle after the end strobe. No error is raised.
- R7: Under the same condition as R6, a non-zero CRC gives a one-cycle `pec_err_o` pulse in the cycle after the end strobe.
- R8: A write message whose byte count equals `len_nopec_i` raises neither `pec_ok_o` nor `pec_err_o`.
- R9: A message that had a repeated START never raises `pec_ok_o` or `pec_err_o` at its end.
- R10: Outside a transaction (before the first START, or after an end strobe), byte strobes do not change `pec_o`. End strobes raise no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | START seen on the bus |
| rstart_i | input | 1 | Repeated START seen on the bus |
| stop_i | input | 1 | End of message |
| byte_vld_i | input | 1 | A byte was transferred on the bus |
| byte_i | input | 8 | Byte value |
| len_nopec_i | input | CNT_W | Write message length without PEC, counting the address byte |
| pec_o | output | 8 | Running CRC; the PEC to append on a read |
| pec_ok_o | output | 1 | One-cycle pulse: write carried a correct PEC |
| pec_err_o | output | 1 | One-cycle pulse: write carried a wrong PEC |

## Verification
The hardest case to reach is a read whose byte count would look like a PEC-bearing write. The bench builds a read of address, command, repeated START, read address and two slave bytes. It sets `len_nopec_i` so the count matches the PEC position, then confirms that no pulse follows the end strobe. A matched pair of writes covers the accept and reject branches. Both carry the same bytes, with a trailing PEC that is either the bench's own CRC or that value with one bit flipped.

// File: rtl/smb_pec_unit.sv
module smb_pec_unit #(
  parameter int         CNT_W = 6,
  parameter logic [7:0] POLY  = 8'h07
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             rstart_i,
  input  logic             stop_i,
  input  logic             byte_vld_i,
  input  logic [7:0]       byte_i,
  input  logic [CNT_W-1:0] len_nopec_i,
  output logic [7:0]       pec_o,
  output logic             pec_ok_o,
  output logic             pec_err_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [7:0]       crc;
  logic [CNT_W-1:0] cnt;
  logic             active;
  logic             rd_phase;
  logic             ok_q;
  logic             err_q;
  logic             pec_slot;

  function automatic logic [7:0] crc_step(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] x;
    x = c ^ d;
    for (int i = 0; i < 8; i++)
      x = x[7] ? ((x << 1) ^ POLY) : (x << 1);
    return x;
  endfunction

  assign pec_slot = ({1'b0, cnt} == ({1'b0, len_nopec_i} + (CNT_W+1)'(1)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      crc      <= 8'h00;
      cnt      <= '0;
      active   <= 1'b0;
      rd_phase <= 1'b0;
      ok_q     <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      ok_q  <= 1'b0;
      err_q <= 1'b0;
      if (start_i) begin
        crc      <= 8'h00;
        cnt      <= '0;
        active   <= 1'b1;
        rd_phase <= 1'b0;
      end else if (active) begin
        if (stop_i) begin
          active <= 1'b0;
          if (!rd_phase && pec_slot) begin
            ok_q  <= (crc == 8'h00);
            err_q <= (crc != 8'h00);
          end
        end else begin
          if (rstart_i) rd_phase <= 1'b1;
          if (byte_vld_i) begin
            crc <= crc_step(crc, byte_i);
            if (cnt != CNT_MAX) cnt <= cnt + CNT_W'(1);
          end
        end
      end
    end
  end

  assign pec_o     = crc;
  assign pec_ok_o  = ok_q;
  assign pec_err_o = err_q;

  AST_START_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (pec_o == 8'h00)); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && !byte_vld_i) |=> $stable(pec_o)); // R4
  AST_OK_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    pec_ok_o |-> ($past(stop_i) && !pec_err_o)); // R6
  AST_ERR_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    pec_err_o |-> $past(stop_i)); // R7
  AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    pec_err_o |=> !pec_err_o); // R7
  AST_READ_NO_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && !start_i && rd_phase) |=> (!pec_err_o && !pec_ok_o)); // R9

endmodule

// File: tb/test_smb_pec_unit.sv
module test_smb_pec_unit;
  localparam int CLK_P = 10;
  localparam int CNT_W = 6;
  localparam int NVEC  = 4;
  localparam logic [99:0] VEC [NVEC] = '{
    {4'd9, 72'h313233343536373839, 24'h0},
    {4'd1, 8'h00, 88'h0},
    {4'd2, 16'hB421, 80'h0},
    {4'd5, 40'hFF800155AA, 56'h0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 0, rstart_i = 0, stop_i = 0, byte_vld_i = 0;
  logic [7:0] byte_i = 8'h00;
  logic [CNT_W-1:0] len_nopec_i = '0;
  logic [7:0] pec_o;
  logic pec_ok_o, pec_err_o;
  int n_chk = 0, n_err = 0;
  logic [7:0] m;

  always #(CLK_P/2) clk = ~clk;

  smb_pec_unit #(.CNT_W(CNT_W)) i_smb_pec_unit (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .rstart_i(rstart_i),
    .stop_i(stop_i), .byte_vld_i(byte_vld_i), .byte_i(byte_i),
    .len_nopec_i(len_nopec_i), .pec_o(pec_o), .pec_ok_o(pec_ok_o),
    .pec_err_o(pec_err_o));

  function automatic logic [7:0] mdl(input logic [7:0] c, input logic [7:0] b);
    logic fb;
    for (int i = 7; i >= 0; i--) begin
      fb = c[7] ^ b[i];
      c  = {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
    end
    return c;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic s, input logic r, input logic p, input logic v, input logic [7:0] b);
    start_i = s; rstart_i = r; stop_i = p; byte_vld_i = v; byte_i = b;
    @(negedge clk);
    start_i = 0; rstart_i = 0; stop_i = 0; byte_vld_i = 0;
  endtask

  task automatic send(input logic [7:0] b);
    cyc(0, 0, 0, 1, b);
    m = mdl(m, b);
  endtask

  initial begin
    #(CLK_P * 100000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 pec", pec_o, 8'h00);
    chk("R1 ok/err", {6'b0, pec_ok_o, pec_err_o}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    cyc(0, 0, 0, 1, 8'h5A);
    chk("R10 byte before start", pec_o, 8'h00);

    for (int v = 0; v < NVEC; v++) begin
      cyc(1, 0, 0, 0, 8'h00);
      m = 8'h00;
      chk("R2 start clears", pec_o, 8'h00);
      for (int k = 0; k < int'(VEC[v][99:96]); k++) begin
        send(VEC[v][95-8*k -: 8]);
        chk("R3 running crc", pec_o, m);
      end
      if (v == 0) chk("R3 known 123456789", pec_o, 8'hF4);
      len_nopec_i = CNT_W'(VEC[v][99:96]);
      cyc(0, 0, 1, 0, 8'h00);
      chk("R8 no pec no pulse", {6'b0, pec_ok_o, pec_err_o}, 8'h00);
    end

    m = pec_o;
    cyc(0, 0, 0, 1, 8'hC3);
    chk("R10 byte after stop", pec_o, m);
    len_nopec_i = '0;
    cyc(0, 0, 1, 0, 8'h00);
    chk("R10 stop outside", {6'b0, pec_ok_o, pec_err_o}, 8'h00);

    m = pec_o;
    repeat (3) @(negedge clk);
    chk("R4 hold idle", pec_o, m);

    cyc(1, 0, 0, 1, 8'h77);
    chk("R2 start beats byte", pec_o, 8'h00);

    m = 8'h00;
    send(8'hB4); send(8'h8B);
    cyc(0, 1, 0, 0, 8'h00);
    chk("R5 rstart keeps crc", pec_o, m);
    send(8'hB5); send(8'h12); send(8'h34);
    chk("R5 read pec", pec_o, m);
    len_nopec_i = CNT_W'(4);
    cyc(0, 0, 1, 0, 8'h00);
    chk("R9 read no pulse", {6'b0, pec_ok_o, pec_err_o}, 8'h00);

    cyc(1, 0, 0, 0, 8'h00);
    m = 8'h00;
    send(8'hB4); send(8'h21); send(8'h5A);
    send(m);
    chk("R6 crc zero", pec_o, 8'h00);
    len_nopec_i = CNT_W'(3);
    cyc(0, 0, 1, 0, 8'h00);
    chk("R6 ok pulse", {6'b0, pec_ok_o, pec_err_o}, 8'h02);
    @(negedge clk);
    chk("R6 ok one cycle", {6'b0, pec_ok_o, pec_err_o}, 8'h00);

    cyc(1, 0, 0, 0, 8'h00);
    m = 8'h00;
    send(8'hB4); send(8'h21); send(8'h5A);
    send(m ^ 8'h01);
    cyc(0, 0, 1, 0, 8'h00);
    chk("R7 err pulse", {6'b0, pec_ok_o, pec_err_o}, 8'h01);
    @(negedge clk);
    chk("R7 err one cycle", {6'b0, pec_ok_o, pec_err_o}, 8'h00);

    cyc(1, 0, 0, 0, 8'h00);
    send(8'hB4); send(8'h21); send(8'h5A);
    cyc(0, 0, 1, 0, 8'h00);
    chk("R8 short write no err", {6'b0, pec_ok_o, pec_err_o}, 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule